// File: doc/BRIEF.md
# Four-Lane Seven-to-One Serial Transmitter

This block turns a stream of 28-bit parallel words into four serial lanes and a fifth framing lane. One word is taken per pixel clock period. A bit clock at seven times the pixel rate, and a one-cycle load strobe that marks each word boundary in that clock, come from outside the block, for example from a clock multiplier. Each lane carries a 7-bit slice of the word. The framing lane repeats a fixed 7-bit clock shape, so a receiver can find the word boundaries and rebuild the pixel clock.

A select input chooses whether input words are captured on the rising or on the falling edge of the pixel clock. The captured word is copied into a holding register in the bit-clock domain at a fixed phase after each load strobe, when it is known to be stable. On the next load strobe the holding register goes into all five shift registers together. An active-low power-down input clears every register synchronously and keeps all outputs at 0. After release, nothing is sent until the first load strobe at which a freshly held word is ready.

Top module: `quad_serial_tx`

## Requirements
- R1: Input bits 7L to 7L+6 of `din` are sent on `lane_out[L]` for L = 0..3.
- R2: Each slice is sent least significant bit first, one bit per bit clock. All lanes load a new word on the bit-clock edge where `word_load` is high, and `word_load` is high once every 7 bit clocks.
- R3: With `edge_sel` = 1 the word is captured on the rising edge of `pix_clk`. With `edge_sel` = 0 it is captured on the falling edge.
- R4: `clk_lane` sends 1,1,0,0,0,1,1 in slots 0 to 6 of every word, with slot 0 in the same bit period as bit 0 of the data lanes.
- R5: While `pwr_n` is low, every register is cleared on each bit-clock and pixel-clock edge, and `lane_out` and `clk_lane` are 0 from the first bit-clock edge that samples `pwr_n` low.
- R6: After `pwr_n` rises, all lanes and `clk_lane` stay 0 until the first load strobe at which a word captured after the release is in the holding register. The first word sent is the first word captured after release.
- R7: The holding register samples the captured word HOLD_PH+1 bit clocks after a load strobe. Every captured word is sent once, in capture order, on the load strobe that follows its hold sample.
- R8: Changes on `din` and `edge_sel` while `pwr_n` is low have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock, seven times the pixel rate |
| pix_clk | input | 1 | Pixel clock that paces the input words |
| pwr_n | input | 1 | Active-low power-down and synchronous clear |
| edge_sel | input | 1 | 1: capture on rising pixel edge, 0: on falling edge |
| word_load | input | 1 | Load strobe in the bit-clock domain, high one cycle in seven |
| din | input | 28 | Parallel input word |
| lane_out | output | 4 | Serial data lanes, bit L is lane L |
| clk_lane | output | 1 | Serial framing clock lane |

## Verification
The bench builds the block with its default parameters: four lanes of 7 bits, a hold phase of 3 and the 1100011 clock shape. With a hold phase of 3, the hold sample falls well clear of both pixel edges. This makes both capture modes reachable in one run without timing races. In each mode the bench offers a valid word only around the selected edge and puts garbage around the opposite edge, so a wrong edge choice brings a wrong word out of the lanes. Power-down is entered in mid-stream and released just before a load strobe. This covers the quiet outputs, the first-word alignment and the switch of capture edge.

// File: rtl/qst_pkg.sv
// Package: shared types for the four-lane serial transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package qst_pkg;

    // Sequencer progress after a clear: waiting for a strobe, framed, sending.
    typedef enum logic [1:0] {
        SEQ_OFF  = 2'd0,
        SEQ_SYNC = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/edge_capture.sv
// Module: edge_capture
// Captures a parallel word on one edge of the pixel clock. The FALLING
// parameter picks the edge. A synchronous active-low clear empties the
// register and drops the valid flag.
// Assumes: clr_n is stable around the selected edge.
module edge_capture #(
    parameter int W       = 28,
    parameter bit FALLING = 1'b0
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         vld
);

    generate
        if (FALLING) begin : g_fall
            // Take the word on the falling pixel edge.
            always_ff @(negedge clk) begin
                if (!clr_n) begin
                    q   <= '0;
                    vld <= 1'b0;
                end else begin
                    q   <= d;
                    vld <= 1'b1;
                end
            end
        end else begin : g_rise
            // Take the word on the rising pixel edge.
            always_ff @(posedge clk) begin
                if (!clr_n) begin
                    q   <= '0;
                    vld <= 1'b0;
                end else begin
                    q   <= d;
                    vld <= 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/word_sequencer.sv
// Module: word_sequencer
// Bit-clock-domain control. It counts the phase from each load strobe and
// copies the captured word into a holding register at HOLD_PH. It decides
// when the shift registers may load, which is after the first strobe that
// finds a held word.
// Assumes: the load strobe comes every SLICE bit clocks, and the captured
// word does not change near phase HOLD_PH.
module word_sequencer
    import qst_pkg::*;
#(
    parameter int W       = 28,
    parameter int SLICE   = 7,
    parameter int HOLD_PH = 3
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_i,
    input  logic [W-1:0] cap_word,
    input  logic         cap_vld,
    output logic [W-1:0] hold_q,
    output logic         load_fire,
    output logic         xmit_on
);

    localparam int PW = (SLICE > 1) ? $clog2(SLICE) : 1;
    localparam logic [PW-1:0] PH_LAST = PW'(SLICE - 1);
    localparam logic [PW-1:0] PH_HOLD = PW'(HOLD_PH);

    seq_state_e    st;
    logic [PW-1:0] ph;
    logic          hold_vld;

    // Load the lanes only once framed and a held word exists.
    always_comb begin
        load_fire = load_i && ((st == SEQ_RUN) || ((st == SEQ_SYNC) && hold_vld));
    end

    assign xmit_on = (st == SEQ_RUN);

    // Phase counter, holding register and state progress.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            st       <= SEQ_OFF;
            ph       <= '0;
            hold_q   <= '0;
            hold_vld <= 1'b0;
        end else begin
            if (load_i) begin
                ph <= '0;
            end else if (ph != PH_LAST) begin
                ph <= ph + 1'b1;
            end
            if ((st != SEQ_OFF) && !load_i && (ph == PH_HOLD) && cap_vld) begin
                hold_q   <= cap_word;
                hold_vld <= 1'b1;
            end
            case (st)
                SEQ_OFF:  if (load_i) st <= SEQ_SYNC;
                SEQ_SYNC: if (load_fire) st <= SEQ_RUN;
                default:  st <= SEQ_RUN;
            endcase
        end
    end

endmodule

// File: rtl/lane_shifter.sv
// Module: lane_shifter
// One parallel-load shift register. It loads a slice and then shifts it
// out least significant bit first, filling with zeros.
// Assumes: load comes no more often than once per SLICE clocks.
module lane_shifter #(
    parameter int SLICE = 7
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load,
    input  logic [SLICE-1:0] par,
    output logic             ser
);

    logic [SLICE-1:0] sh;

    // Load on strobe, otherwise move one bit toward the output.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            sh <= '0;
        end else if (load) begin
            sh <= par;
        end else begin
            sh <= sh >> 1;
        end
    end

    assign ser = sh[0];

endmodule

// File: rtl/quad_serial_tx.sv
// Module: quad_serial_tx (top)
// Captures a word per pixel clock on the chosen edge, holds it in the
// bit-clock domain and sends it as LANES serial slices plus a framing
// clock lane. pwr_n low clears everything synchronously.
// Assumes: bit_clk is SLICE times pix_clk and phase-locked to it, and
// word_load marks each word boundary in bit_clk.
module quad_serial_tx #(
    parameter int               LANES   = 4,
    parameter int               SLICE   = 7,
    parameter int               HOLD_PH = 3,
    parameter logic [SLICE-1:0] CLK_PAT = 7'b1100011
) (
    input  logic                   bit_clk,
    input  logic                   pix_clk,
    input  logic                   pwr_n,
    input  logic                   edge_sel,
    input  logic                   word_load,
    input  logic [LANES*SLICE-1:0] din,
    output logic [LANES-1:0]       lane_out,
    output logic                   clk_lane
);

    localparam int W = LANES * SLICE;

    logic [W-1:0]           cap_rise, cap_fall, cap_word;
    logic                   vld_rise, vld_fall, cap_vld;
    logic [W-1:0]           hold_word;
    logic                   load_fire, xmit_on;
    logic [W+SLICE-1:0]     slab;
    logic [LANES:0]         ser_bits;

    edge_capture #(.W(W), .FALLING(1'b0)) u_cap_rise (
        .clk(pix_clk), .clr_n(pwr_n), .d(din), .q(cap_rise), .vld(vld_rise)
    );

    edge_capture #(.W(W), .FALLING(1'b1)) u_cap_fall (
        .clk(pix_clk), .clr_n(pwr_n), .d(din), .q(cap_fall), .vld(vld_fall)
    );

    // Pick the capture register that matches the strobe edge.
    always_comb begin
        cap_word = edge_sel ? cap_rise : cap_fall;
        cap_vld  = edge_sel ? vld_rise : vld_fall;
    end

    word_sequencer #(.W(W), .SLICE(SLICE), .HOLD_PH(HOLD_PH)) u_seq (
        .clk(bit_clk), .clr_n(pwr_n), .load_i(word_load),
        .cap_word(cap_word), .cap_vld(cap_vld),
        .hold_q(hold_word), .load_fire(load_fire), .xmit_on(xmit_on)
    );

    assign slab = {CLK_PAT, hold_word};

    generate
        for (genvar g = 0; g <= LANES; g++) begin : g_lane
            lane_shifter #(.SLICE(SLICE)) u_sh (
                .clk(bit_clk), .clr_n(pwr_n), .load(load_fire),
                .par(slab[g*SLICE +: SLICE]), .ser(ser_bits[g])
            );
        end
    endgenerate

    assign lane_out = ser_bits[LANES-1:0];
    assign clk_lane = ser_bits[LANES];

endmodule

// File: rtl/quad_serial_tx_chk.sv
// Module: quad_serial_tx_chk
// Checker bound to quad_serial_tx. It watches the outputs against the
// sequencer's load decision and the holding register.
// Assumes: bound through the bind statement at the end of this file.
module quad_serial_tx_chk #(
    parameter int LANES = 4,
    parameter int SLICE = 7
) (
    input logic                   bit_clk,
    input logic                   pwr_n,
    input logic [LANES-1:0]       lane_out,
    input logic                   clk_lane,
    input logic                   load_fire,
    input logic                   xmit_on,
    input logic [LANES*SLICE-1:0] hold_word
);

    logic [LANES-1:0] first_bits;
    logic             pd_seen;

    // Bit 0 of each slice of the held word.
    always_comb begin
        for (int l = 0; l < LANES; l++) first_bits[l] = hold_word[l*SLICE];
    end

    // R5: once an edge has seen pwr_n low, the outputs are quiet.
    always_ff @(posedge bit_clk) begin
        if (pd_seen) begin
            p_pd_quiet_r5: assert (lane_out == '0 && !clk_lane)
                else $error("p_pd_quiet_r5");
        end
        pd_seen <= !pwr_n;
    end

    // R1, R2: the bit period after a load shows bit 0 of each slice.
    p_first_bit_r1: assert property (@(posedge bit_clk) disable iff (!pwr_n)
        load_fire |=> lane_out == $past(first_bits));

    // R4: the clock lane starts each word high.
    p_clk_start_r4: assert property (@(posedge bit_clk) disable iff (!pwr_n)
        load_fire |=> clk_lane);

    // R4: slot 2 of the clock lane is low.
    p_clk_slot2_r4: assert property (@(posedge bit_clk) disable iff (!pwr_n)
        load_fire |=> ##2 !clk_lane);

    // R6: before transmission starts, every lane is 0.
    p_idle_quiet_r6: assert property (@(posedge bit_clk) disable iff (!pwr_n)
        !xmit_on |-> (lane_out == '0 && !clk_lane));

endmodule

bind quad_serial_tx quad_serial_tx_chk #(.LANES(LANES), .SLICE(SLICE)) u_chk (
    .bit_clk(bit_clk), .pwr_n(pwr_n), .lane_out(lane_out), .clk_lane(clk_lane),
    .load_fire(load_fire), .xmit_on(xmit_on), .hold_word(hold_word)
);

// File: tb/tb_quad_serial_tx.sv
`timescale 1ns/100ps
// Bench: a driver offers words around the chosen pixel edge and pushes them
// into a queue. A monitor rebuilds words from the lanes and compares.
module tb_quad_serial_tx;

    localparam int LANES = 4;
    localparam int SLICE = 7;
    localparam int W     = LANES * SLICE;
    localparam logic [SLICE-1:0] PAT = 7'b1100011;

    logic             bit_clk = 1'b0;
    logic             pix_clk = 1'b0;
    logic             pwr_n = 1'b0;
    logic             edge_sel = 1'b1;
    logic             word_load = 1'b0;
    logic [W-1:0]     din = '0;
    logic [LANES-1:0] lane_out;
    logic             clk_lane;

    int           checks = 0;
    int           fails = 0;
    int           nb = 0;
    logic [W-1:0] exp_q[$];

    bit           framed = 1'b0;
    bit           pd_prev = 1'b0;
    bit           clk_bad = 1'b0;
    int           slot = 0;
    logic [W-1:0] acc = '0;

    quad_serial_tx dut (
        .bit_clk(bit_clk), .pix_clk(pix_clk), .pwr_n(pwr_n), .edge_sel(edge_sel),
        .word_load(word_load), .din(din), .lane_out(lane_out), .clk_lane(clk_lane)
    );

    always #2.5 bit_clk = ~bit_clk;

    initial begin
        #1;
        forever begin
            pix_clk = 1'b1;
            #17.5;
            pix_clk = 1'b0;
            #17.5;
        end
    end

    // Load strobe: high for the posedge at 2.5 ns past each 35 ns boundary.
    always @(negedge bit_clk) begin
        nb++;
        word_load = (nb % 7 == 0);
    end

    task automatic fail_msg(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        fails++;
        $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    endtask

    // Take one sampled bit period into the current word.
    task automatic take_slot();
        logic [W-1:0] want;
        if (slot == 0) clk_bad = 1'b0;
        if (clk_lane != PAT[slot]) clk_bad = 1'b1;
        for (int l = 0; l < LANES; l++) acc[l*SLICE + slot] = lane_out[l];
        if (slot == SLICE - 1) begin
            checks++;
            if (clk_bad) fail_msg("R4 clock lane shape", W'(0), W'(PAT));
            if (exp_q.size() > 0) begin
                checks++;
                if (exp_q.size() > 3) fail_msg("R7 latency", W'(exp_q.size()), W'(3));
                want = exp_q.pop_front();
                checks++;
                if (acc !== want) fail_msg("R1,R2,R3 word", acc, want);
            end
        end
    endtask

    // Monitor: deserialize in the middle of each bit period.
    always @(negedge bit_clk) begin
        if (pd_prev && !pwr_n) begin
            checks++;
            if (lane_out !== '0 || clk_lane !== 1'b0)
                fail_msg("R5,R8 quiet in power-down", W'({clk_lane, lane_out}), W'(0));
        end
        if (!pwr_n) begin
            framed = 1'b0;
        end else if (!framed) begin
            if (clk_lane === 1'b1) begin
                framed = 1'b1;
                slot = 0;
                take_slot();
            end else begin
                checks++;
                if (lane_out !== '0) fail_msg("R6 idle lanes", W'(lane_out), W'(0));
            end
        end else begin
            slot = (slot + 1) % SLICE;
            take_slot();
        end
        pd_prev = !pwr_n;
    end

    function automatic logic [W-1:0] pick_word(input int i);
        case (i)
            0: return 28'h0000001;
            1: return 28'h8000000;
            2: return 28'hFFFFFFF;
            3: return 28'h0204081;
            4: return 28'h7F00000;
            default: return W'($urandom);
        endcase
    endfunction

    // Release power-down 0.5 ns after a rising pixel edge, just before a strobe.
    task automatic release_pd();
        @(posedge pix_clk);
        #0.5;
        pwr_n = 1'b1;
    endtask

    // Valid word near the selected edge, garbage near the opposite edge.
    task automatic drive_words(input bit rising, input int n);
        if (rising) #26.5; else #9;
        for (int i = 0; i < n; i++) begin
            din = pick_word(i);
            exp_q.push_back(din);
            #16;
            din = W'($urandom);
            #19;
        end
    endtask

    task automatic drain();
        #(35 * 6);
        checks++;
        if (exp_q.size() != 0) fail_msg("R7 every word sent", W'(exp_q.size()), W'(0));
        exp_q.delete();
    endtask

    // Enter power-down and wiggle inputs that must have no effect (R8).
    task automatic power_down();
        pwr_n = 1'b0;
        for (int k = 0; k < 4; k++) begin
            #35;
            din = W'($urandom);
            edge_sel = ~edge_sel;
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #40;
        checks++;
        if (lane_out !== '0 || clk_lane !== 1'b0)
            fail_msg("R5 reset state", W'({clk_lane, lane_out}), W'(0));
        edge_sel = 1'b1;
        release_pd();
        drive_words(1'b1, 20);
        drain();
        power_down();
        edge_sel = 1'b0;
        release_pd();
        drive_words(1'b0, 20);
        drain();
        power_down();
        edge_sel = 1'b1;
        release_pd();
        drive_words(1'b1, 6);
        drain();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule